// File: doc/BRIEF.md
# DMA Transfer Queue Control Registers

This block is the software-facing control plane of a single-channel DMA engine. Software programs the transfer options, reads the ID that the next transfer will carry, and writes a start command. The block then holds that descriptor in a one-entry queue slot and offers it to the transfer engine over a valid/ready handshake. Each submitted transfer carries a small ID. When the engine finishes a transfer, it returns that ID on a completion strobe, and the block records it in a bitmask that software can read.

Two interrupt sources are provided. Start-of-transfer fires when the engine takes the queued descriptor, which means the slot is free again. End-of-transfer fires when a completion arrives. Each source has a pending bit, a mask bit and a masked-source view, and the three feed one interrupt line. Software learns that the queue is full by reading back the start register. The engine can be paused, which holds the offer back. Writing zero to the enable bit abandons any queued work.

Descriptor handoff rules: `desc_valid` rises only when the slot is occupied, the engine is enabled and the engine is not paused. While `desc_valid` is high and `desc_ready` is low, `desc_id` and `desc_cyclic` hold steady. The descriptor is taken on the clock edge where both signals are high. The completion strobe has no back-pressure: each cycle with `done_valid` high is one completion.

Top module: `xfer_queue_regs`

## Requirements
- R1: After reset, the following all read 0: control, pending, transfer-ID, start, done mask and status. The mask register (0x080) reads 3. `desc_valid` and `irq` are low.
- R2: A write to start (0x408) with bit 0 set, while enabled and the slot is empty, fills the slot:
  - the descriptor takes the current next-ID (0x404) and takes flags bit 0 (0x40C) as its cyclic mark;
  - the next-ID then advances by one, modulo 4;
  - reading start returns 1 while the slot is occupied and 0 otherwise.
- R3: A start write is ignored in two cases: while the slot is occupied, and while control bit 0 is clear. In both cases neither the next-ID nor the slot changes.
- R4: `desc_valid` is high exactly when three conditions hold: the slot is occupied, control bit 0 (enable) is set and control bit 1 (pause) is clear. While the offer waits, `desc_id` and `desc_cyclic` stay stable. Pausing drops the offer but keeps the slot.
- R5: A control write with bit 0 clear empties the slot on that edge. The next-ID is not rewound.
- R6: On the edge where `desc_valid` and `desc_ready` are both high, three things happen: the slot empties, the active-ID register (0x42C, bits 1:0) takes the accepted ID, and pending bit 0 (start-of-transfer) sets.
- R7: On the edge where `done_valid` is high, done-mask bit `done_id` (0x428) sets and pending bit 1 (end-of-transfer) sets.
- R8: A done-mask bit clears on the edge where its ID is given to a new submission.
- R9: Pending (0x084) is write-one-to-clear. If an event sets a bit on the same edge that clears it, the set wins.
- R10: The interrupt path works as follows:
  - a mask bit of 1 disables its source;
  - the masked-source register (0x088) reads pending AND NOT mask;
  - `irq` is the OR of the masked-source bits;
  - pending bits still latch while their source is masked.
- R11: Status (0x430) reports bit 0 slot occupied, bit 1 enable and bit 2 pause. Register reads are combinational. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| desc_valid | output | 1 | Descriptor offered to the engine |
| desc_ready | input | 1 | Engine takes the offered descriptor |
| desc_id | output | 2 | ID of the offered descriptor |
| desc_cyclic | output | 1 | Offered descriptor repeats cyclically |
| done_valid | input | 1 | Completion strobe from the engine |
| done_id | input | 2 | ID of the completed transfer |
| engine_enable | output | 1 | Control enable bit |
| engine_pause | output | 1 | Control pause bit |
| irq | output | 1 | Interrupt line |

## Verification
Register writes, descriptor acceptance and completion strobes all update state on one clock edge. Their effects show on reads and ports from the following cycle onward, while reads and `irq` follow combinationally with no added delay. The bench therefore drives every stimulus at a falling edge and lets exactly one rising edge pass. It then samples at the next falling edge, so each check lands in the first cycle its result is due. Hold behaviour is checked by waiting several cycles with `desc_ready` low.

// File: rtl/xq_pkg.sv
package xq_pkg;
  localparam int unsigned OFS_IRQ_MASK = 'h080;
  localparam int unsigned OFS_IRQ_PEND = 'h084;
  localparam int unsigned OFS_IRQ_SRC  = 'h088;
  localparam int unsigned OFS_CTRL     = 'h400;
  localparam int unsigned OFS_NEXT_ID  = 'h404;
  localparam int unsigned OFS_START    = 'h408;
  localparam int unsigned OFS_FLAGS    = 'h40C;
  localparam int unsigned OFS_DONE     = 'h428;
  localparam int unsigned OFS_ACTIVE   = 'h42C;
  localparam int unsigned OFS_STATUS   = 'h430;

  localparam int IRQ_SOT = 0;
  localparam int IRQ_EOT = 1;
  localparam int IRQ_N   = 2;

  typedef struct packed {
    logic pause;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/xq_slot.sv
module xq_slot #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            submit_req,
  input  logic            enable,
  input  logic            pause,
  input  logic            abandon,
  input  logic            cyclic_in,
  input  logic            ready,
  output logic            valid,
  output logic            full,
  output logic            accept,
  output logic            submit,
  output logic [ID_W-1:0] slot_id,
  output logic [ID_W-1:0] next_id,
  output logic            slot_cyc
);
  assign submit = submit_req & enable & ~full & ~abandon;
  assign valid  = full & enable & ~pause;
  assign accept = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      slot_id  <= '0;
      slot_cyc <= 1'b0;
      next_id  <= '0;
    end else if (abandon || accept) begin
      full <= 1'b0;
    end else if (submit) begin
      full     <= 1'b1;
      slot_id  <= next_id;
      slot_cyc <= cyclic_in;
      next_id  <= next_id + ID_W'(1);
    end
  end
endmodule

// File: rtl/xq_done.sv
module xq_done #(
  parameter int ID_W = 2,
  localparam int NUM_IDS = 1 << ID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [ID_W-1:0]    set_id,
  input  logic               clr_en,
  input  logic [ID_W-1:0]    clr_id,
  output logic [NUM_IDS-1:0] mask
);
  for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                mask[i] <= 1'b0;
      else if (set_en && set_id == ID_W'(i))     mask[i] <= 1'b1;
      else if (clr_en && clr_id == ID_W'(i))     mask[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/xq_irq.sv
module xq_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] pend,
  output logic [N-1:0] mask,
  output logic [N-1:0] src,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (set_vec[i]) pend[i] <= 1'b1;
      else if (clr_vec[i]) pend[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '1;
    else if (mask_we) mask <= mask_wdata;
  end

  assign src = pend & ~mask;
  assign irq = |src;
endmodule

// File: rtl/xfer_queue_regs.sv
module xfer_queue_regs
  import xq_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [ID_W-1:0]   desc_id,
  output logic              desc_cyclic,
  input  logic              done_valid,
  input  logic [ID_W-1:0]   done_id,
  output logic              engine_enable,
  output logic              engine_pause,
  output logic              irq
);
  localparam int NUM_IDS = 1 << ID_W;

  ctrl_t             ctrl_q;
  logic              flag_cyc_q;
  logic [ID_W-1:0]   active_q;
  logic              slot_full, accept, submit;
  logic [ID_W-1:0]   next_id;
  logic [NUM_IDS-1:0] done_mask;
  logic [IRQ_N-1:0]  pend, mask, src;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_ctrl, wr_flags, wr_start, wr_pend, wr_mask;
  assign wr_ctrl  = reg_wen & hit(reg_addr, OFS_CTRL);
  assign wr_flags = reg_wen & hit(reg_addr, OFS_FLAGS);
  assign wr_start = reg_wen & hit(reg_addr, OFS_START) & reg_wdata[0];
  assign wr_pend  = reg_wen & hit(reg_addr, OFS_IRQ_PEND);
  assign wr_mask  = reg_wen & hit(reg_addr, OFS_IRQ_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      flag_cyc_q <= 1'b0;
      active_q   <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q     <= '{pause: reg_wdata[1], enable: reg_wdata[0]};
      if (wr_flags) flag_cyc_q <= reg_wdata[0];
      if (accept)   active_q   <= desc_id;
    end
  end

  xq_slot #(.ID_W(ID_W)) i_slot (
    .clk(clk), .rst_n(rst_n), .submit_req(wr_start),
    .enable(ctrl_q.enable), .pause(ctrl_q.pause),
    .abandon(wr_ctrl & ~reg_wdata[0]), .cyclic_in(flag_cyc_q),
    .ready(desc_ready), .valid(desc_valid), .full(slot_full),
    .accept(accept), .submit(submit), .slot_id(desc_id),
    .next_id(next_id), .slot_cyc(desc_cyclic)
  );

  xq_done #(.ID_W(ID_W)) i_done (
    .clk(clk), .rst_n(rst_n), .set_en(done_valid), .set_id(done_id),
    .clr_en(submit), .clr_id(next_id), .mask(done_mask)
  );

  logic [IRQ_N-1:0] irq_set;
  always_comb begin
    irq_set = '0;
    irq_set[IRQ_SOT] = accept;
    irq_set[IRQ_EOT] = done_valid;
  end

  xq_irq #(.N(IRQ_N)) i_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(irq_set),
    .clr_vec(wr_pend ? reg_wdata[IRQ_N-1:0] : '0),
    .mask_we(wr_mask), .mask_wdata(reg_wdata[IRQ_N-1:0]),
    .pend(pend), .mask(mask), .src(src), .irq(irq)
  );

  assign engine_enable = ctrl_q.enable;
  assign engine_pause  = ctrl_q.pause;

  always_comb begin
    reg_rdata = '0;
    if      (hit(reg_addr, OFS_IRQ_MASK)) reg_rdata = DATA_W'(mask);
    else if (hit(reg_addr, OFS_IRQ_PEND)) reg_rdata = DATA_W'(pend);
    else if (hit(reg_addr, OFS_IRQ_SRC))  reg_rdata = DATA_W'(src);
    else if (hit(reg_addr, OFS_CTRL))     reg_rdata = DATA_W'(ctrl_q);
    else if (hit(reg_addr, OFS_NEXT_ID))  reg_rdata = DATA_W'(next_id);
    else if (hit(reg_addr, OFS_START))    reg_rdata = DATA_W'(slot_full);
    else if (hit(reg_addr, OFS_FLAGS))    reg_rdata = DATA_W'(flag_cyc_q);
    else if (hit(reg_addr, OFS_DONE))     reg_rdata = DATA_W'(done_mask);
    else if (hit(reg_addr, OFS_ACTIVE))   reg_rdata = DATA_W'(active_q);
    else if (hit(reg_addr, OFS_STATUS))
      reg_rdata = DATA_W'({ctrl_q.pause, ctrl_q.enable, slot_full});
  end
endmodule

// File: rtl/xq_checker.sv
module xq_checker
  import xq_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 12,
  localparam int NUM_IDS = 1 << ID_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wen,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               desc_valid,
  input logic               desc_ready,
  input logic [ID_W-1:0]    desc_id,
  input logic               desc_cyclic,
  input logic               done_valid,
  input logic [ID_W-1:0]    done_id,
  input logic               engine_enable,
  input logic               irq,
  input logic [IRQ_N-1:0]   pend,
  input logic [NUM_IDS-1:0] done_mask,
  input logic               slot_full,
  input logic [ID_W-1:0]    next_id
);
  logic ctrl_wr, start_wr;
  assign ctrl_wr  = reg_wen && reg_addr == ADDR_W'(OFS_CTRL);
  assign start_wr = reg_wen && reg_addr == ADDR_W'(OFS_START);

  assert_offer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready && !ctrl_wr |=> desc_valid && $stable(desc_id) && $stable(desc_cyclic));

  assert_no_offer_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_enable |-> !desc_valid);

  assert_full_no_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && slot_full |=> $stable(next_id));

  assert_sot_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> pend[IRQ_SOT] && !slot_full);

  assert_eot_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> pend[IRQ_EOT] && done_mask[$past(done_id)]);

  assert_quiet_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend == '0 |-> !irq);
endmodule

bind xfer_queue_regs xq_checker #(.ID_W(ID_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_id(desc_id),
  .desc_cyclic(desc_cyclic), .done_valid(done_valid), .done_id(done_id),
  .engine_enable(engine_enable), .irq(irq), .pend(pend),
  .done_mask(done_mask), .slot_full(slot_full), .next_id(next_id)
);

// File: tb/test_xfer_queue_regs.sv
`timescale 1ns/1ps
module test_xfer_queue_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        desc_valid, desc_cyclic, engine_enable, engine_pause, irq;
  logic        desc_ready = 1'b0;
  logic [1:0]  desc_id;
  logic        done_valid = 1'b0;
  logic [1:0]  done_id = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xfer_queue_regs i_xfer_queue_regs (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_id(desc_id), .desc_cyclic(desc_cyclic),
    .done_valid(done_valid), .done_id(done_id), .engine_enable(engine_enable),
    .engine_pause(engine_pause), .irq(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [11:0] a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h400, 32'h0, 8'd1},   // R1 control
    '{1'b1, 12'h404, 32'h0, 8'd1},   // R1 next-ID
    '{1'b1, 12'h408, 32'h0, 8'd1},   // R1 start
    '{1'b1, 12'h080, 32'h3, 8'd1},   // R1 mask
    '{1'b1, 12'h084, 32'h0, 8'd1},   // R1 pending
    '{1'b1, 12'h428, 32'h0, 8'd1},   // R1 done mask
    '{1'b1, 12'h430, 32'h0, 8'd11},  // R11 status
    '{1'b1, 12'h100, 32'h0, 8'd11},  // R11 unmapped
    '{1'b0, 12'h40C, 32'h1, 8'd0},
    '{1'b0, 12'h408, 32'h1, 8'd0},   // start while disabled
    '{1'b1, 12'h404, 32'h0, 8'd3},   // R3
    '{1'b1, 12'h408, 32'h0, 8'd3},   // R3
    '{1'b0, 12'h400, 32'h1, 8'd0},
    '{1'b0, 12'h408, 32'h1, 8'd0},
    '{1'b1, 12'h408, 32'h1, 8'd2},   // R2 full
    '{1'b1, 12'h404, 32'h1, 8'd2},   // R2 advance
    '{1'b1, 12'h430, 32'h3, 8'd11},  // R11
    '{1'b0, 12'h408, 32'h1, 8'd0},   // start while full
    '{1'b1, 12'h404, 32'h1, 8'd3},   // R3
    '{1'b0, 12'h400, 32'h0, 8'd0},   // abandon
    '{1'b1, 12'h408, 32'h0, 8'd5},   // R5
    '{1'b1, 12'h404, 32'h1, 8'd5},   // R5 no rewind
    '{1'b1, 12'h430, 32'h0, 8'd5}    // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic take();
    @(negedge clk); desc_ready = 1'b1;
    @(negedge clk); desc_ready = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 desc_valid", desc_valid, 0);
    chk("R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        @(negedge clk);
        rd($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].a, VEC[i].d);
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end

    // R4 offer after submit
    wr(12'h400, 1); wr(12'h408, 1);
    chk("R4 valid", desc_valid, 1);
    chk("R4 id", desc_id, 1);
    chk("R4 cyclic", desc_cyclic, 1);
    wr(12'h400, 3);
    chk("R4 pause drops valid", desc_valid, 0);
    rd("R11 status paused", 12'h430, 7);
    wr(12'h400, 1);
    repeat (3) @(negedge clk);
    chk("R4 hold valid", desc_valid, 1);
    chk("R4 hold id", desc_id, 1);

    // R6 acceptance
    take();
    chk("R6 slot empties", desc_valid, 0);
    rd("R6 start", 12'h408, 0);
    rd("R6 active id", 12'h42C, 1);
    rd("R6 sot pending", 12'h084, 1);
    chk("R10 masked line", irq, 0);
    wr(12'h080, 2);
    chk("R10 unmasked line", irq, 1);
    rd("R10 source", 12'h088, 1);
    wr(12'h084, 1);
    chk("R9 line after clear", irq, 0);
    rd("R9 pending cleared", 12'h084, 0);

    // R7 completion
    @(negedge clk); done_valid = 1'b1; done_id = 2'd1;
    @(negedge clk); done_valid = 1'b0;
    rd("R7 done mask", 12'h428, 2);
    rd("R7 eot pending", 12'h084, 2);
    chk("R10 eot masked", irq, 0);
    wr(12'h084, 2);

    // R9 set wins over clear on the same edge
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 12'h084; reg_wdata = 32'h3;
    done_valid = 1'b1; done_id = 2'd3;
    @(negedge clk);
    reg_wen = 1'b0; done_valid = 1'b0;
    rd("R9 set wins", 12'h084, 2);
    rd("R7 done id3", 12'h428, 32'hA);
    wr(12'h084, 2);

    // R8 done bit cleared on ID reissue, with ID wrap
    @(negedge clk); done_valid = 1'b1; done_id = 2'd0;
    @(negedge clk); done_valid = 1'b0;
    rd("R7 done id0", 12'h428, 32'hB);
    wr(12'h40C, 0);
    wr(12'h408, 1); take();
    wr(12'h408, 1);
    rd("R8 id3 reissue", 12'h428, 32'h3);
    take();
    wr(12'h408, 1);
    rd("R8 id0 reissue", 12'h428, 32'h2);
    chk("R2 wrapped id", desc_id, 0);
    chk("R2 non-cyclic", desc_cyclic, 0);
    rd("R2 next after wrap", 12'h404, 1);

    finish_up();
  end
endmodule